// File: doc/BRIEF.md
# Multiple-Input Signature Compaction Register

This block folds a long stream of 8-bit data words into a single 8-bit signature. A test or benchmark that produces far more results than can be kept can run them all through the block. Its completeness and correctness are then judged from the one word left at the end. Every accepted word is absorbed in one clock.

On each accepted word the signature moves up by one bit, and the bit leaving the top is dropped. The incoming word is XORed in bit for bit. If the signature's top bit was set before the move, a fixed feedback pattern is also XORed in. A synchronous clear brings the signature back to zero before a new run. An expected-signature input is compared against the live signature, and the result is given as a registered match flag.

Top module: `sig_compactor`

## Requirements
- R1: While `rst` is high at a rising edge, the signature becomes 8'h00 and `match` becomes 0 after that edge.
- R2: With `din_vld`=1, `clr`=0, `din`=8'h00 and signature bit 7 equal to 0, the next signature is the current one shifted one place toward bit 7, with bit 0 set to 0.
- R3: Each bit `din[i]` is XORed into signature bit i of the shifted value, so from 8'h00 an accepted word `d` yields `d`.
- R4: When signature bit 7 is 1 before an accepted word, the pattern 8'h63 (bits 6, 5, 1 and 0) is also XORed into the shifted result, and the old bit 7 is discarded. For example, 8'h80 with `din`=8'h00 gives 8'h63.
- R5: For each accepted word, the next signature is ((s<<1) ^ din ^ (s[7] ? 8'h63 : 8'h00)) & 8'hFF. It is visible on `sig` right after the edge that accepts the word.
- R6: When `clr` is 1 at a rising edge, the signature becomes 8'h00, even if `din_vld` is also 1.
- R7: When `din_vld` is 0 and `clr` is 0, the signature keeps its value whatever `din` holds.
- R8: `match` after a rising edge equals (signature held before that edge == `exp_sig` at that edge). It therefore reports a final update one cycle after that update appears on `sig`.
- R9: A stream of 65,536 words made of the low 8 bits of an incrementing counter gives the same signature as a per-word model. Changing any single bit of a single word changes the final signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the signature; wins over `din_vld` |
| din_vld | input | 1 | Accept `din` in this cycle |
| din | input | 8 | Data word to fold in |
| exp_sig | input | 8 | Expected signature for comparison |
| sig | output | 8 | Current signature |
| match | output | 1 | Registered equality of `sig` and `exp_sig` |

## Verification
A word, clear or idle cycle driven before edge k shows its effect on `sig` just after edge k. The `match` flag for that same edge compares the signature held before it, so a final update appears on `match` one edge after it appears on `sig`. The bench queues, for every driven cycle, the signature and match value due after the next edge. A monitor samples 1 ns after each rising edge and pops one entry per edge, so every comparison falls in exactly the cycle its result is due. The long counter streams are checked the same way, word by word, before their final signatures are compared against each other.

// File: rtl/sigcomp_pkg.sv
package sigcomp_pkg;

    parameter int SIG_W = 8;
    parameter logic [SIG_W-1:0] FB_DEFAULT = 8'h63;

    typedef logic [SIG_W-1:0] sig_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_FOLD  = 2'b01,
        OP_CLEAR = 2'b10
    } sig_op_e;

    typedef struct packed {
        sig_op_e op;
        sig_t    data;
    } word_cmd_t;

    function automatic sig_op_e decode_op(logic clr, logic vld);
        if (clr)      return OP_CLEAR;
        else if (vld) return OP_FOLD;
        else          return OP_HOLD;
    endfunction

endpackage

// File: rtl/sig_fold.sv
module sig_fold
    import sigcomp_pkg::*;
#(
    parameter sig_t FB_MASK = FB_DEFAULT
) (
    input  sig_t cur,
    input  sig_t data,
    output sig_t nxt
);
    localparam int MSB = SIG_W - 1;

    logic fb_on;
    assign fb_on = cur[MSB];

    for (genvar i = 0; i < SIG_W; i++) begin : g_cell
        logic shifted_bit;
        if (i == 0) begin : g_low
            assign shifted_bit = 1'b0;
        end else begin : g_up
            assign shifted_bit = cur[i-1];
        end
        assign nxt[i] = shifted_bit ^ data[i] ^ (fb_on & FB_MASK[i]);
    end
endmodule

// File: rtl/sig_store.sv
module sig_store
    import sigcomp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_cmd_t cmd,
    input  sig_t      nxt,
    output sig_t      sig
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sig <= '0;
        end else begin
            unique case (cmd.op)
                OP_CLEAR: sig <= '0;
                OP_FOLD:  sig <= nxt;
                default:  sig <= sig;
            endcase
        end
    end

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_CLEAR |=> sig == '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_HOLD |=> $stable(sig));

    p_update_r5: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_FOLD |=> sig == $past(nxt));

    p_reset_r1: assert property (@(posedge clk)
        rst |=> sig == '0);
endmodule

// File: rtl/sig_compare.sv
module sig_compare
    import sigcomp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sig_t sig,
    input  sig_t exp_sig,
    output logic match
);
    always_ff @(posedge clk) begin
        if (rst) match <= 1'b0;
        else     match <= (sig == exp_sig);
    end

    p_match_lag_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> match == ($past(sig) == $past(exp_sig)));

    p_match_reset_r1: assert property (@(posedge clk)
        rst |=> !match);
endmodule

// File: rtl/sig_compactor.sv
module sig_compactor
    import sigcomp_pkg::*;
#(
    parameter sig_t FB_MASK = FB_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             din_vld,
    input  logic [SIG_W-1:0] din,
    input  logic [SIG_W-1:0] exp_sig,
    output logic [SIG_W-1:0] sig,
    output logic             match
);
    localparam int MSB = SIG_W - 1;

    word_cmd_t cmd;
    sig_t      nxt;

    assign cmd.op   = decode_op(clr, din_vld);
    assign cmd.data = din;

    sig_fold #(.FB_MASK(FB_MASK)) u_fold (
        .cur  (sig),
        .data (cmd.data),
        .nxt  (nxt)
    );

    sig_store u_store (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .nxt (nxt),
        .sig (sig)
    );

    sig_compare u_cmp (
        .clk     (clk),
        .rst     (rst),
        .sig     (sig),
        .exp_sig (exp_sig),
        .match   (match)
    );

    p_shift_only_r2: assert property (@(posedge clk) disable iff (rst)
        (din_vld && !clr && din == '0 && !sig[MSB])
        |=> sig == {$past(sig[MSB-1:0]), 1'b0});

    p_feedback_r4: assert property (@(posedge clk) disable iff (rst)
        (din_vld && !clr && din == '0 && sig[MSB])
        |=> sig == ({$past(sig[MSB-1:0]), 1'b0} ^ FB_MASK));

    p_data_in_r3: assert property (@(posedge clk) disable iff (rst)
        (din_vld && !clr && sig == '0) |=> sig == $past(din));
endmodule

// File: tb/tb_sig_compactor.sv
module tb_sig_compactor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       din_vld = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] exp_sig = 8'h00;
    logic [7:0] sig;
    logic       match;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] q_sig[$];
    logic       q_match[$];
    string      q_tag[$];

    logic [7:0] model = 8'h00;

    always #2 clk = ~clk;

    sig_compactor dut (
        .clk(clk), .rst(rst), .clr(clr), .din_vld(din_vld),
        .din(din), .exp_sig(exp_sig), .sig(sig), .match(match)
    );

    function automatic logic [7:0] ref_step(logic [7:0] s, logic [7:0] d);
        logic [7:0] r;
        r = {s[6:0], 1'b0} ^ d;
        if (s[7]) r = r ^ 8'b0110_0011;
        return r;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic drive(logic c, logic v, logic [7:0] d, logic [7:0] e, string tag);
        @(negedge clk);
        clr = c; din_vld = v; din = d; exp_sig = e;
        q_match.push_back(model == e);
        if (c)      model = 8'h00;
        else if (v) model = ref_step(model, d);
        q_sig.push_back(model);
        q_tag.push_back(tag);
    endtask

    // monitor: one queue entry per edge, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (q_sig.size() > 0) begin
            logic [7:0] es;
            logic       em;
            string      t;
            es = q_sig.pop_front();
            em = q_match.pop_front();
            t  = q_tag.pop_front();
            check({t, " sig"}, sig, es);
            check({"R8 match/", t}, {7'b0, match}, {7'b0, em});
        end
    end

    task automatic run_stream(int flip_word, logic [7:0] flip_mask, output logic [7:0] fin);
        drive(1'b1, 1'b0, 8'h00, 8'h00, "R6");
        for (int i = 0; i < 65536; i++) begin
            logic [7:0] w;
            w = i[7:0];
            if (i == flip_word) w = w ^ flip_mask;
            drive(1'b0, 1'b1, w, 8'h00, "R9");
        end
        fin = model;
        drive(1'b0, 1'b0, 8'h00, 8'h00, "R7");
    endtask

    initial begin
        logic [7:0] clean_fin, err_fin;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 sig", sig, 8'h00);
        check("R1 match", {7'b0, match}, 8'h00);
        rst = 1'b0;

        drive(1'b0, 1'b1, 8'h01, 8'h00, "R3");
        for (int k = 0; k < 7; k++) drive(1'b0, 1'b1, 8'h00, 8'h00, "R2");
        drive(1'b0, 1'b1, 8'h00, 8'h00, "R4");          // 80 -> 63
        drive(1'b0, 1'b0, 8'hFF, 8'h63, "R7");          // hold, R8 match high
        drive(1'b0, 1'b0, 8'h5A, 8'h63, "R7");
        drive(1'b1, 1'b1, 8'hAA, 8'h00, "R6");          // clear beats valid
        drive(1'b0, 1'b1, 8'hC3, 8'h00, "R3");
        drive(1'b0, 1'b1, 8'h3C, 8'h11, "R5");
        drive(1'b0, 1'b1, 8'hF0, 8'h22, "R5");
        drive(1'b0, 1'b1, 8'h0F, 8'h33, "R5");
        drive(1'b0, 1'b1, 8'h81, 8'h44, "R5");
        drive(1'b0, 1'b0, 8'h00, model, "R8");
        drive(1'b0, 1'b0, 8'h00, 8'h00, "R8");

        run_stream(-1, 8'h00, clean_fin);
        run_stream(40000, 8'h10, err_fin);
        @(negedge clk);
        @(negedge clk);
        n_vec++;
        if (clean_fin == err_fin) begin
            n_bad++;
            $display("FAIL R9 single-bit error: actual %h expected not %h", err_fin, clean_fin);
        end

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule